// File: doc/BRIEF.md
# Masked Vector Integer-to-Float Converter

This block turns a vector of signed 32-bit integer lanes into IEEE-754 single-precision lanes in one registered stage. A per-lane write mask decides which lanes receive a converted value. A lane that is masked off either keeps its previous destination contents (merge) or is cleared (zero). A memory-sourced operand can be broadcast, so that element 0 feeds every lane. The rounding direction normally comes from a global mode field. A per-operation override replaces it only for full-width register operands that have the override flag set.

The caller presents the source vector, the old destination vector and the control fields, and pulses `in_valid`. One clock later `out_valid` is high and the result vector and the inexact flag are ready. Destination bits above the active length are cleared. The one exception is a legacy compatibility mode, which runs at a fixed quarter width and passes those upper bits through from the old destination.

Top module: `i2f_lanes`

## Requirements
- R1: `vlen_sel` picks the active lane count. 00 selects LANES/4 lanes (4 by default), 01 selects LANES/2 (8) and 10 or 11 selects LANES (16). Outside legacy mode, all result bits above the active lanes are 0.
- R2: Lane j converts source bits [32j+31:32j], read as two's complement, to single precision. 0 gives 0x00000000, 1 gives 0x3F800000, 100 gives 0x42C80000 and -2^31 gives 0xCF000000.
- R3: The rounding code selects the direction. 00 is nearest-even (ties go to the even significand), 01 is toward minus infinity, 10 is toward plus infinity and 11 is toward zero.
- R4: `op_rnd` is used only when `vlen_sel` is 10 or 11, `src_is_mem`=0, `bcast_rc`=1 and legacy mode is off. In every other case `glob_rnd` is used.
- R5: With `mask_en`=1, an active lane whose `lane_mask` bit is 0 holds its `old_dst` value when `zero_mask`=0 and is set to 0 when `zero_mask`=1. With `mask_en`=0, every active lane is written regardless of `lane_mask`.
- R6: When `bcast_rc`=1 and `src_is_mem`=1, every active lane converts source bits [31:0]. With `src_is_mem`=0, each lane converts its own slice.
- R7: With `legacy`=1, the lane count is fixed at LANES/4, every such lane is written, `glob_rnd` is used and bits above the first LANES/4 lanes come from `old_dst`. In this mode the mask, broadcast and length fields have no effect.
- R8: `inexact` is the OR, over the lanes actually written, of "the integer needs more than 24 significand bits to be exact". Masked-off or inactive lanes contribute nothing.
- R9: The results and `out_valid` appear one clock after `in_valid`. They hold their values while `in_valid` is low. Reset clears `res_vec`, `inexact` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| vlen_sel | input | 2 | Active length code |
| legacy | input | 1 | Fixed quarter-width compatibility mode |
| src_vec | input | 32*LANES | Integer source lanes |
| old_dst | input | 32*LANES | Previous destination contents |
| lane_mask | input | LANES | Per-lane write enables |
| mask_en | input | 1 | Apply lane_mask |
| zero_mask | input | 1 | 1: clear masked lanes, 0: keep old value |
| bcast_rc | input | 1 | Broadcast (memory source) / rounding override (register source) |
| src_is_mem | input | 1 | Source came from memory |
| op_rnd | input | 2 | Per-operation rounding code |
| glob_rnd | input | 2 | Global rounding code |
| out_valid | output | 1 | Result present |
| res_vec | output | 32*LANES | Converted, masked result |
| inexact | output | 1 | Precision condition of the written lanes |

## Verification
Every result is due exactly one clock after the `in_valid` pulse. The bench raises `in_valid` at a falling edge and drops it at the next falling edge. It then samples `res_vec`, `inexact` and `out_valid` at that second falling edge, half a period after the capturing rising edge. For the hold checks it waits further idle cycles and samples again at falling edges. The single-lane rounding corners are walked through a vector table. The masking, broadcast, override, length and legacy cases are directed and checked lane by lane.

// File: rtl/i2f_lanes.sv
module i2f_lanes #(
  parameter int LANES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          vlen_sel,
  input  logic                legacy,
  input  logic [32*LANES-1:0] src_vec,
  input  logic [32*LANES-1:0] old_dst,
  input  logic [LANES-1:0]    lane_mask,
  input  logic                mask_en,
  input  logic                zero_mask,
  input  logic                bcast_rc,
  input  logic                src_is_mem,
  input  logic [1:0]          op_rnd,
  input  logic [1:0]          glob_rnd,
  output logic                out_valid,
  output logic [32*LANES-1:0] res_vec,
  output logic                inexact
);
  localparam int VW = 32 * LANES;
  localparam int Q_LANES = LANES / 4;
  localparam int H_LANES = LANES / 2;

  function automatic logic [32:0] to_single(input logic [31:0] x, input logic [1:0] rm);
    logic        s;
    logic [31:0] mag, nrm;
    logic [4:0]  lz;
    logic        g, st, up;
    logic [24:0] sig;
    logic [7:0]  e;
    logic [22:0] frac;
    s   = x[31];
    mag = s ? (~x + 32'd1) : x;
    lz  = 5'd0;
    for (int i = 0; i < 32; i++)
      if (mag[i]) lz = 5'(31 - i);
    nrm = mag << lz;
    g   = nrm[7];
    st  = |nrm[6:0];
    case (rm)
      2'b00:   up = g & (st | nrm[8]);
      2'b01:   up = s & (g | st);
      2'b10:   up = ~s & (g | st);
      default: up = 1'b0;
    endcase
    sig  = {1'b0, nrm[31:8]} + {24'd0, up};
    e    = 8'd158 - {3'd0, lz};
    frac = sig[22:0];
    if (sig[24]) begin
      e    = e + 8'd1;
      frac = 23'd0;
    end
    if (mag == 32'd0) return 33'd0;
    return {g | st, s, e, frac};
  endfunction

  logic [4:0] n_act;
  logic       use_op;
  logic [1:0] rmode;
  logic       bcast;

  assign n_act  = legacy ? 5'(Q_LANES) :
                  (vlen_sel == 2'b00) ? 5'(Q_LANES) :
                  (vlen_sel == 2'b01) ? 5'(H_LANES) : 5'(LANES);
  assign use_op = ~legacy & vlen_sel[1] & ~src_is_mem & bcast_rc;
  assign rmode  = use_op ? op_rnd : glob_rnd;
  assign bcast  = ~legacy & bcast_rc & src_is_mem;

  logic [VW-1:0]    nxt_vec;
  logic [LANES-1:0] lane_inx;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [31:0] src_j, old_j;
    logic [32:0] cv;
    logic        act, wr;
    assign src_j = bcast ? src_vec[31:0] : src_vec[32*j +: 32];
    assign old_j = old_dst[32*j +: 32];
    assign cv    = to_single(src_j, rmode);
    assign act   = 5'(j) < n_act;
    assign wr    = legacy | ~mask_en | lane_mask[j];
    assign lane_inx[j] = act & wr & cv[32];
    assign nxt_vec[32*j +: 32] = !act ? (legacy ? old_j : 32'd0) :
                                 wr ? cv[31:0] :
                                 zero_mask ? 32'd0 : old_j;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec <= nxt_vec;
        inexact <= |lane_inx;
      end
    end
  end
endmodule

// File: rtl/i2f_lanes_chk.sv
module i2f_lanes_chk #(
  parameter int LANES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          vlen_sel,
  input logic                legacy,
  input logic [32*LANES-1:0] old_dst,
  input logic [LANES-1:0]    lane_mask,
  input logic                mask_en,
  input logic                zero_mask,
  input logic                out_valid,
  input logic [32*LANES-1:0] res_vec,
  input logic                inexact
);
  localparam int VW = 32 * LANES;
  localparam int QW = VW / 4;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_vec) && $stable(inexact)); // R9
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen_sel == 2'b00) |=> res_vec[VW-1:QW] == '0); // R1
  AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && mask_en && zero_mask && lane_mask == '0) |=> res_vec == '0); // R5
  AST_MERGE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && mask_en && !zero_mask && lane_mask == '0 && vlen_sel[1])
    |=> res_vec == $past(old_dst)); // R5
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy) |=> res_vec[VW-1:QW] == $past(old_dst[VW-1:QW])); // R7
  AST_NO_INEXACT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && mask_en && lane_mask == '0) |=> !inexact); // R8
endmodule

bind i2f_lanes i2f_lanes_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/i2f_lanes_test.sv
module i2f_lanes_test;
  localparam int CLK_NS = 10;
  localparam int LANES = 16;
  localparam int VW = 32 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] vlen_sel = 2'b00;
  logic legacy = 1'b0;
  logic [VW-1:0] src_vec = '0;
  logic [VW-1:0] old_dst = '0;
  logic [LANES-1:0] lane_mask = '0;
  logic mask_en = 1'b0, zero_mask = 1'b0, bcast_rc = 1'b0, src_is_mem = 1'b0;
  logic [1:0] op_rnd = 2'b00, glob_rnd = 2'b00;
  logic out_valid, inexact;
  logic [VW-1:0] res_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  i2f_lanes #(.LANES(LANES)) uut (.*);

  // {integer, rounding code, expected float, expected inexact}
  localparam logic [66:0] VEC [16] = '{
    {32'h00000000, 2'b00, 32'h00000000, 1'b0},
    {32'h00000001, 2'b00, 32'h3F800000, 1'b0},
    {32'hFFFFFFFF, 2'b00, 32'hBF800000, 1'b0},
    {32'h80000000, 2'b00, 32'hCF000000, 1'b0},
    {32'h00000064, 2'b00, 32'h42C80000, 1'b0},
    {32'h01000000, 2'b00, 32'h4B800000, 1'b0},
    {32'h7FFFFFFF, 2'b00, 32'h4F000000, 1'b1},
    {32'h7FFFFFFF, 2'b11, 32'h4EFFFFFF, 1'b1},
    {32'h7FFFFFFF, 2'b10, 32'h4F000000, 1'b1},
    {32'h7FFFFFFF, 2'b01, 32'h4EFFFFFF, 1'b1},
    {32'h01000001, 2'b00, 32'h4B800000, 1'b1},
    {32'h01000001, 2'b10, 32'h4B800001, 1'b1},
    {32'h01000003, 2'b00, 32'h4B800002, 1'b1},
    {32'hFEFFFFFF, 2'b01, 32'hCB800001, 1'b1},
    {32'hFEFFFFFF, 2'b10, 32'hCB800000, 1'b1},
    {32'hFEFFFFFF, 2'b11, 32'hCB800000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_lane(input string req, input int j, input logic [31:0] exp);
    chk(req, res_vec[32*j +: 32], exp);
  endtask

  task automatic pulse();
    @(negedge clk) in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic defaults();
    vlen_sel = 2'b00; legacy = 0; mask_en = 0; zero_mask = 0; bcast_rc = 0;
    src_is_mem = 0; op_rnd = 2'b00; glob_rnd = 2'b00; lane_mask = '0;
    src_vec = '0; old_dst = '0;
  endtask

  task automatic fill_src(input logic [31:0] v);
    for (int j = 0; j < LANES; j++) src_vec[32*j +: 32] = v;
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 reset inexact", {31'd0, inexact}, 32'd0);
    chk("R9 reset res", res_vec[31:0], 32'd0);
    rst_n = 1'b1;

    // R2 R3 table walk
    for (int k = 0; k < 16; k++) begin
      defaults();
      src_vec[31:0] = VEC[k][66:35];
      glob_rnd = VEC[k][34:33];
      pulse();
      chk("R2/R3 value", res_vec[31:0], VEC[k][32:1]);
      chk("R8 inexact", {31'd0, inexact}, {31'd0, VEC[k][0]});
      chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
    end

    // R1 lane counts
    for (int c = 0; c < 3; c++) begin
      defaults(); fill_src(32'd1); old_dst = {VW{1'b1}};
      vlen_sel = 2'(c);
      pulse();
      for (int j = 0; j < LANES; j++)
        chk_lane("R1 length", j, (j < (4 << c)) ? 32'h3F800000 : 32'd0);
    end

    // R5 merge, zero, mask disabled
    defaults(); fill_src(32'd1); old_dst = {LANES{32'hAAAAAAAA}};
    vlen_sel = 2'b10; mask_en = 1; lane_mask = 16'h00FF;
    pulse();
    for (int j = 0; j < LANES; j++) chk_lane("R5 merge", j, (j < 8) ? 32'h3F800000 : 32'hAAAAAAAA);
    zero_mask = 1;
    pulse();
    for (int j = 0; j < LANES; j++) chk_lane("R5 zero", j, (j < 8) ? 32'h3F800000 : 32'd0);
    mask_en = 0; lane_mask = '0;
    pulse();
    for (int j = 0; j < LANES; j++) chk_lane("R5 no mask", j, 32'h3F800000);

    // R6 broadcast
    defaults(); vlen_sel = 2'b10; bcast_rc = 1; src_is_mem = 1;
    for (int j = 0; j < LANES; j++) src_vec[32*j +: 32] = 32'(j + 1);
    pulse();
    for (int j = 0; j < LANES; j++) chk_lane("R6 broadcast", j, 32'h3F800000);
    src_is_mem = 0;
    pulse();
    chk_lane("R6 own slice", 1, 32'h40000000);
    chk_lane("R6 own slice", 3, 32'h40800000);

    // R4 rounding override
    defaults(); fill_src(32'h7FFFFFFF); vlen_sel = 2'b10; bcast_rc = 1;
    glob_rnd = 2'b00; op_rnd = 2'b11;
    pulse();
    chk_lane("R4 override used", 0, 32'h4EFFFFFF);
    vlen_sel = 2'b01;
    pulse();
    chk_lane("R4 short length global", 0, 32'h4F000000);
    vlen_sel = 2'b10; src_is_mem = 1;
    pulse();
    chk_lane("R4 memory global", 5, 32'h4F000000);
    src_is_mem = 0; bcast_rc = 0;
    pulse();
    chk_lane("R4 flag clear global", 0, 32'h4F000000);

    // R7 legacy
    defaults(); fill_src(32'd1); old_dst = {LANES{32'h55555555}};
    legacy = 1; vlen_sel = 2'b10; mask_en = 1; zero_mask = 1; lane_mask = '0;
    bcast_rc = 1; op_rnd = 2'b11;
    src_vec[31:0] = 32'h7FFFFFFF;
    pulse();
    chk_lane("R7 lane0 global round", 0, 32'h4F000000);
    chk_lane("R7 lane written", 3, 32'h3F800000);
    chk_lane("R7 upper kept", 4, 32'h55555555);
    chk_lane("R7 upper kept", 15, 32'h55555555);

    // R8 inexact over written lanes only
    defaults(); fill_src(32'd1); src_vec[63:32] = 32'h7FFFFFFF;
    mask_en = 1; lane_mask = 16'hFFFD;
    pulse();
    chk("R8 masked lane ignored", {31'd0, inexact}, 32'd0);
    lane_mask = 16'hFFFF;
    pulse();
    chk("R8 written lane counts", {31'd0, inexact}, 32'd1);
    defaults(); fill_src(32'd1); src_vec[32*4 +: 32] = 32'h7FFFFFFF;
    pulse();
    chk("R8 inactive lane ignored", {31'd0, inexact}, 32'd0);

    // R9 hold while idle
    defaults(); fill_src(32'h00000064); pulse();
    src_vec = '0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid low", {31'd0, out_valid}, 32'd0);
    chk_lane("R9 result held", 0, 32'h42C80000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule